// File: doc/BRIEF.md
# Burst-Capable Synchronous SRAM Control Front End

This block sits in front of a small word-wide memory array and takes every control, address and data input on the rising clock edge. On each edge it decides between three actions. It can take a fresh external address. It can keep working through a burst that is already open. Or it can go idle. Each access, once accepted, is a read or a write of the selected word. Two address strobes can start a burst: a processor-side strobe and a controller-side strobe. The processor-side strobe is gated by the first chip enable. Both strobes also need the remaining enable terms, and those terms are examined only on cycles where a strobe is asserted.

An open burst walks through the four words of an aligned group. A 2-bit counter replaces the two low address bits, and the upper bits stay frozen. One static pin chooses between a wrapping linear count and an interleaved (XOR) count. The burst feature is optional: a new address may be presented on back-to-back cycles with no idle cycle between them.

Writes are qualified per byte. A global-write input writes the whole word. Otherwise a byte-write enable combined with individual byte selects writes only the chosen bytes. Read data is registered and is presented one cycle after the access, together with a valid flag.

Top module: `sram_burst_front`

## Requirements
- R1: When `pstrb_n` is low and `ce1_n` is low, and both `ce2` is high and `ce3_n` is low, `addr` is captured and that word is read. `rvalid` is high and `rdata` holds the word on the following cycle.
- R2: When `cstrb_n` is low with all enables active (and R1 does not apply), `addr` is captured. That word is written if the write controls request a write, otherwise it is read.
- R3: On a cycle with no accepted strobe while a burst is open, the address advances one step if `step_n` is low. If `step_n` is high the current address is reused. The word at that address is read or written per the write controls.
- R4: With `order_lin_n` low, the low two address bits of beat k are (start + k) mod 4.
- R5: With `order_lin_n` high, the low two address bits of beat k are start XOR k.
- R6: With `ce1_n` high, a low `pstrb_n` is treated as not asserted. An open burst then continues, and an idle block stays idle.
- R7: An asserted strobe with `ce2` low or `ce3_n` high closes any burst and makes no access, and later strobe-free cycles make no access. Burst-continuation cycles ignore `ce2` and `ce3_n`.
- R8: With `gwr_n` high and `bwe_n` low, byte b (bits 8b+7..8b) is written only where `bsel_n[b]` is low, and other bytes keep their value. With no byte selected, the access is a read.
- R9: With `gwr_n` low, all four bytes are written regardless of `bwe_n` and `bsel_n`.
- R10: When both strobes are low, the processor-side strobe wins. A cycle accepted through it is always a read, even when write controls are asserted, and memory is unchanged.
- R11: During a burst the upper address bits stay at the captured value, so a burst wraps within its aligned four-word group.
- R12: A new address may be captured on every cycle, and each such read returns data on the next cycle with no gap.
- R13: While `rst_n` is low, `rvalid` is low and `rdata` is zero, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | First chip enable, active low, also gates the processor-side strobe |
| ce2 | input | 1 | Second chip enable, active high, examined only with a strobe |
| ce3_n | input | 1 | Third chip enable, active low, examined only with a strobe |
| pstrb_n | input | 1 | Processor-side address strobe, active low |
| cstrb_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_lin_n | input | 1 | Burst order: low = linear, high = interleaved |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NBYTE | Per-byte write selects, active low |
| wdata | input | NBYTE*BYTE_W | Write data |
| rdata | output | NBYTE*BYTE_W | Registered read data |
| rvalid | output | 1 | High when `rdata` holds the result of the previous cycle's read |

## Verification
The hardest situation to reach from the ports is a burst that is open while other inputs try to disturb it. Examples are a processor strobe masked by `ce1_n`, enable terms going inactive on continuation cycles, and advance gaps that fall on the wrap point. Random stimulus seldom lines these up by chance. The bench therefore first fills the whole array through controller-strobe writes, so every later read has a known value. It then drives directed sequences that open a burst at a non-zero start in each order and inject these disturbances mid-burst. After that, a long random phase runs with strobes biased rarely asserted, so bursts stay open for many cycles while enables and write controls vary freely.

// File: rtl/sram_burst_front.sv
module sram_burst_front #(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    pstrb_n,
  input  logic                    cstrb_n,
  input  logic                    step_n,
  input  logic                    order_lin_n,
  input  logic                    gwr_n,
  input  logic                    bwe_n,
  input  logic [NBYTE-1:0]        bsel_n,
  input  logic [NBYTE*BYTE_W-1:0] wdata,
  output logic [NBYTE*BYTE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = NBYTE * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        start_q, beat_q;
  logic              active_q;

  wire p_ok  = !pstrb_n && !ce1_n;
  wire any_s = p_ok || !cstrb_n;
  wire sel   = !ce1_n && ce2 && !ce3_n;
  wire load  = any_s && sel;
  wire desel = any_s && !sel;
  wire cont  = !any_s && active_q;
  wire adv   = cont && !step_n;

  wire [1:0] beat_nx = adv ? beat_q + 2'd1 : beat_q;
  wire [1:0] low_nx  = order_lin_n ? (start_q ^ beat_nx) : (start_q + beat_nx);
  wire [ADDR_W-1:0] eff = load ? addr : {hi_q, low_nx};

  wire access = load || cont;
  wire wr_req = !gwr_n || (!bwe_n && (bsel_n != {NBYTE{1'b1}}));
  wire do_wr  = access && !p_ok && wr_req;
  wire do_rd  = access && !do_wr;

  logic [NBYTE-1:0] byte_we;
  always_comb
    for (int b = 0; b < NBYTE; b++)
      byte_we[b] = do_wr && (!gwr_n || !bsel_n[b]);

  always_ff @(posedge clk)
    if (!rst_n) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      start_q  <= 2'd0;
      beat_q   <= 2'd0;
    end else if (load) begin
      active_q <= 1'b1;
      hi_q     <= addr[ADDR_W-1:2];
      start_q  <= addr[1:0];
      beat_q   <= 2'd0;
    end else if (desel) begin
      active_q <= 1'b0;
    end else if (adv) begin
      beat_q   <= beat_nx;
    end

  always_ff @(posedge clk)
    for (int b = 0; b < NBYTE; b++)
      if (byte_we[b]) mem[eff][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];

  always_ff @(posedge clk)
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= do_rd;
      if (do_rd) rdata <= mem[eff];
    end

  a_r1_pstrobe_read: assert property (@(posedge clk) disable iff (!rst_n)
    (p_ok && ce2 && !ce3_n) |=> rvalid);
  a_r10_pstrobe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (p_ok && !gwr_n) |-> (byte_we == '0));
  a_r3_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && pstrb_n && cstrb_n && step_n) |=> $stable(beat_q) && $stable(start_q));
  a_r3_step_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && pstrb_n && cstrb_n && !step_n) |=> (beat_q == $past(beat_q) + 2'd1));
  a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstrb_n && !ce2) |=> (!rvalid && !active_q));
  a_r6_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && ce1_n && cstrb_n) |=> !rvalid);
  a_r11_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && pstrb_n && cstrb_n) |=> $stable(hi_q));
  a_r13_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!rvalid && !active_q));
endmodule

// File: tb/test_sram_burst_front.sv
module test_sram_burst_front;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  addr = 0;
  logic        ce1_n = 1, ce2 = 0, ce3_n = 1, pstrb_n = 1, cstrb_n = 1, step_n = 1;
  logic        order_lin_n = 0, gwr_n = 1, bwe_n = 1;
  logic [3:0]  bsel_n = 4'hF;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        rvalid;

  sram_burst_front i_sram_burst_front (.clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .step_n(step_n),
    .order_lin_n(order_lin_n), .gwr_n(gwr_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mdl [64];
  logic        m_act = 0;
  logic [3:0]  m_hi = 0;
  logic [1:0]  m_start = 0, m_beat = 0;
  logic        exp_valid = 0;
  logic [31:0] exp_data = 0;
  string       exp_tag = "R13";

  function automatic logic [1:0] beat_low(logic [1:0] s, logic [1:0] k, logic inter);
    return inter ? (s ^ k) : 2'((s + k) & 2'd3);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic check_out();
    check({exp_tag, " rvalid"}, {31'd0, rvalid}, {31'd0, exp_valid});
    if (exp_valid) check({exp_tag, " rdata"}, rdata, exp_data);
  endtask

  task automatic model(string tag);
    logic pv, strobe, ok, acc, wr;
    logic [5:0] ad;
    string t;
    pv = !pstrb_n && !ce1_n;
    strobe = pv || !cstrb_n;
    ok = !ce1_n && ce2 && !ce3_n;
    acc = 0; ad = 0; t = "R7";
    if (strobe) begin
      if (ok) begin
        m_hi = addr[5:2]; m_start = addr[1:0]; m_beat = 0; m_act = 1;
        acc = 1; ad = addr; t = pv ? "R1" : "R2";
      end else m_act = 0;
    end else if (m_act) begin
      if (!step_n) m_beat = m_beat + 2'd1;
      ad = {m_hi, beat_low(m_start, m_beat, order_lin_n)};
      acc = 1; t = order_lin_n ? "R5" : "R4";
    end
    exp_valid = 0;
    if (acc) begin
      wr = !pv && (!gwr_n || (!bwe_n && bsel_n != 4'hF));
      if (wr) begin
        for (int b = 0; b < 4; b++)
          if (!gwr_n || !bsel_n[b]) mdl[ad][b*8 +: 8] = wdata[b*8 +: 8];
      end else begin
        exp_valid = 1; exp_data = mdl[ad];
      end
    end
    exp_tag = (tag != "") ? tag : t;
  endtask

  task automatic cyc(logic p_n, logic c_n, logic e1n, logic e2, logic e3n, logic stp_n,
                     logic lin_n, logic [5:0] a, logic gw_n, logic bw_n, logic [3:0] bs_n,
                     logic [31:0] wd, string tag);
    @(negedge clk);
    check_out();
    pstrb_n = p_n; cstrb_n = c_n; ce1_n = e1n; ce2 = e2; ce3_n = e3n; step_n = stp_n;
    order_lin_n = lin_n; addr = a; gwr_n = gw_n; bwe_n = bw_n; bsel_n = bs_n; wdata = wd;
    model(tag);
  endtask

  task automatic pread(logic [5:0] a, logic lin_n, string tag);
    cyc(0, 1, 0, 1, 0, 1, lin_n, a, 1, 1, 4'hF, 0, tag);
  endtask
  task automatic cread(logic [5:0] a, string tag);
    cyc(1, 0, 0, 1, 0, 1, 0, a, 1, 1, 4'hF, 0, tag);
  endtask
  task automatic adv(logic stp_n, logic lin_n, string tag);
    cyc(1, 1, 0, 1, 0, stp_n, lin_n, 6'd0, 1, 1, 4'hF, 0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 rvalid", {31'd0, rvalid}, 32'd0);
    check("R13 rdata", rdata, 32'd0);
    rst_n = 1;
    // fill the array back to back (R12)
    for (int i = 0; i < 64; i++)
      cyc(1, 0, 0, 1, 0, 1, 0, 6'(i), 0, 1, 4'hF, 32'hC0DE_0000 ^ (i * 32'h0101_0101), "R12");
    for (int i = 20; i < 26; i++) cread(6'(i), "R12");
    // linear burst from start 2 (R4, R11)
    pread(6'd6, 0, "R1");
    adv(0, 0, "R4"); adv(0, 0, "R11"); adv(0, 0, "R4"); adv(0, 0, "R11");
    // interleaved burst from start 1 (R5), with a hold (R3)
    pread(6'd9, 1, "R1");
    adv(0, 1, "R5"); adv(1, 1, "R3"); adv(0, 1, "R5"); adv(0, 1, "R5");
    // byte write and global write (R8, R9)
    cyc(1, 0, 0, 1, 0, 1, 0, 6'd12, 1, 0, 4'b1010, 32'h1122_3344, "R8");
    cread(6'd12, "R8");
    cyc(1, 0, 0, 1, 0, 1, 0, 6'd13, 1, 0, 4'hF, 32'hFFFF_FFFF, "R8");
    cread(6'd13, "R8");
    cyc(1, 0, 0, 1, 0, 1, 0, 6'd14, 0, 1, 4'hF, 32'h5566_7788, "R9");
    cread(6'd14, "R9");
    // both strobes with write controls: processor wins, read only (R10)
    cyc(0, 0, 0, 1, 0, 1, 0, 6'd15, 0, 0, 4'h0, 32'hDEAD_BEEF, "R10");
    cread(6'd15, "R10");
    // masked processor strobe during burst and while idle (R6)
    pread(6'd32, 0, "R1");
    cyc(0, 1, 1, 1, 0, 0, 0, 6'd50, 1, 1, 4'hF, 0, "R6");
    cyc(1, 0, 0, 0, 0, 1, 0, 6'd0, 1, 1, 4'hF, 0, "R7");
    cyc(0, 1, 1, 1, 0, 0, 0, 6'd50, 1, 1, 4'hF, 0, "R6");
    adv(0, 0, "R7");
    // continuation ignores ce2/ce3_n (R7)
    pread(6'd40, 0, "R1");
    cyc(1, 1, 0, 0, 1, 0, 0, 6'd0, 1, 1, 4'hF, 0, "R7");
    cyc(1, 0, 0, 1, 1, 1, 0, 6'd3, 1, 1, 4'hF, 0, "R7");
    adv(0, 0, "R7");
    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] r;
      r = 7'($urandom_range(0, 99));
      cyc(r < 12 ? 1'b0 : 1'b1, (r >= 10 && r < 22) ? 1'b0 : 1'b1,
          ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) == 0),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)),
          ($urandom_range(0, 7) != 0), ($urandom_range(0, 2) != 0), 4'($urandom_range(0, 15)),
          $urandom(), "");
    end
    @(negedge clk);
    check_out();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule